// File: doc/BRIEF.md
# Register-File LIFO Stack with Full and Empty Flags

This block is a last-in, first-out store built from a bank of flip-flop registers. It holds up to 2^PTR_W words of WIDTH bits (64 words by default). A single pointer names the current top entry. A push first advances the pointer and then writes the incoming word at the new position. A pop returns the word at the pointer and then steps the pointer back. Because fullness is detected when the pointer wraps to zero, every entry, including entry 0, holds data. The first word pushed after reset lands in entry 1.

Requests are single-cycle strobes with no back-pressure. The block never stalls a request. Instead, it drops a request it cannot serve and reports the drop with a one-cycle `err` pulse. A push is dropped while the stack is full. A pop is dropped while the stack is empty. A push is also dropped whenever a pop is requested in the same cycle, because the pop takes priority. Popped words appear on `pop_data`, qualified by a one-cycle `pop_vld` pulse in the cycle after the request. The consumer cannot refuse them, and `pop_data` holds its value until the next accepted pop.

Top module: `lifo_regstack`

## Requirements
- R1: After reset is released, `empty`=1, `full`=0, `pop_vld`=0 and `err`=0.
- R2: Words that are pushed are returned by later pops in reverse order of pushing (last in, first out).
- R3: While `full`=1, a push without a pop sets `err`=1 for one cycle and leaves `full`, the pointer and the stored words unchanged. A later drain returns the original 64 words.
- R4: While `empty`=1, a pop sets `err`=1 for one cycle, gives no `pop_vld`, leaves `pop_data` unchanged and leaves `empty`=1.
- R5: An accepted push clears `empty`. An accepted pop clears `full`. `full` and `empty` are never both 1.
- R6: When `push_vld` and `pop_req` are both 1 in one cycle, the pop is served if the stack is not empty. The push word is discarded and `err` pulses.
- R7: `err` is 1 only in the cycle after a rejected or dropped request. It is 0 after every accepted request and after idle cycles.
- R8: An accepted pop gives `pop_vld`=1 for exactly one cycle, in the cycle after the request, with `pop_data` equal to the top word.
- R9: Capacity is exactly 2^PTR_W words. `full` rises on the 64th push after empty and not before, and `empty` rises on the pop that removes the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_vld | input | 1 | Push request strobe for one cycle |
| push_data | input | WIDTH | Word to push |
| pop_req | input | 1 | Pop request strobe for one cycle |
| pop_vld | output | 1 | One-cycle qualifier for a popped word |
| pop_data | output | WIDTH | Last popped word, held until the next accepted pop |
| full | output | 1 | All entries hold data |
| empty | output | 1 | No entry holds data |
| err | output | 1 | One-cycle pulse after a rejected or dropped request |

## Verification
A push and a pop can be requested in the same cycle. The bench provokes this in three states: on a partly filled stack, on a full stack and on an empty stack. The random phases also produce it often. In each case the result is judged against a bench model in which the pop wins. The model expects the top word on `pop_data`, an `err` pulse, and no trace of the pushed word when the stack is drained later. When the stack is empty, the model instead expects both requests to be refused with nothing changed.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stack_op_e;
endpackage

// File: rtl/stack_arbiter.sv
module stack_arbiter
  import stack_pkg::*;
(
  input  logic      push_vld,
  input  logic      pop_req,
  input  logic      full,
  input  logic      empty,
  output stack_op_e op,
  output logic      reject
);
  // pop has priority; a push that collides with any pop request is dropped
  always_comb begin
    op     = OP_IDLE;
    reject = 1'b0;
    if (pop_req) begin
      if (empty) reject = 1'b1;
      else       op     = OP_POP;
      if (push_vld) reject = 1'b1;
    end else if (push_vld) begin
      if (full) reject = 1'b1;
      else      op     = OP_PUSH;
    end
  end
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr
  import stack_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stack_op_e        op,
  output logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] wr_addr,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] sp_inc;
  logic [PTR_W-1:0] sp_dec;

  assign sp_inc  = sp + PTR_W'(1);
  assign sp_dec  = sp - PTR_W'(1);
  assign wr_addr = sp_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      unique case (op)
        OP_PUSH: begin
          sp    <= sp_inc;
          full  <= (sp_inc == '0);
          empty <= 1'b0;
        end
        OP_POP: begin
          sp    <= sp_dec;
          empty <= (sp_dec == '0);
          full  <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stack_regfile.sv
module stack_regfile #(
  parameter int WIDTH = 16,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << PTR_W;

  logic [WIDTH-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk) begin
      if (we && (waddr == PTR_W'(i))) q <= wdata;
    end
    assign cells[i] = q;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
  import stack_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_vld,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic             pop_vld,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic             empty,
  output logic             err
);
  stack_op_e        op;
  logic             reject;
  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] wr_addr;
  logic [WIDTH-1:0] top_word;

  stack_arbiter u_arb (
    .push_vld (push_vld),
    .pop_req  (pop_req),
    .full     (full),
    .empty    (empty),
    .op       (op),
    .reject   (reject)
  );

  stack_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .sp      (sp_q),
    .wr_addr (wr_addr),
    .full    (full),
    .empty   (empty)
  );

  stack_regfile #(.WIDTH(WIDTH), .PTR_W(PTR_W)) u_rf (
    .clk   (clk),
    .we    (op == OP_PUSH),
    .waddr (wr_addr),
    .wdata (push_data),
    .raddr (sp_q),
    .rdata (top_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_vld  <= 1'b0;
      pop_data <= '0;
      err      <= 1'b0;
    end else begin
      pop_vld <= (op == OP_POP);
      err     <= reject;
      if (op == OP_POP) pop_data <= top_word;
    end
  end
endmodule

// File: rtl/stack_chk.sv
module stack_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_vld,
  input logic             pop_req,
  input logic             pop_vld,
  input logic             full,
  input logic             empty,
  input logic             err,
  input logic [PTR_W-1:0] sp
);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r4_empty_pop_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req) |=> (err && !pop_vld && empty));

  a_r3_full_push_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_vld && !pop_req) |=> (err && full && $stable(sp)));

  a_r6_pop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && pop_req && !empty) |=> (pop_vld && err && !full));

  a_r7_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(push_vld) || $past(pop_req)));

  a_r8_vld_from_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop_vld |-> ($past(pop_req) && !$past(empty)));

  a_r9_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (sp == '0));
endmodule

bind lifo_regstack stack_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push_vld (push_vld),
  .pop_req  (pop_req),
  .pop_vld  (pop_vld),
  .full     (full),
  .empty    (empty),
  .err      (err),
  .sp       (sp_q)
);

// File: tb/test_lifo_regstack.sv
module test_lifo_regstack;
  localparam int W     = 16;
  localparam int PW    = 6;
  localparam int DEPTH = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_vld = 1'b0;
  logic [W-1:0]  push_data = '0;
  logic          pop_req = 1'b0;
  logic          pop_vld;
  logic [W-1:0]  pop_data;
  logic          full;
  logic          empty;
  logic          err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0]  m_mem [DEPTH];
  logic [PW-1:0] m_sp = '0;
  logic          m_full = 1'b0;
  logic          m_empty = 1'b1;
  logic [W-1:0]  m_data = '0;

  always #2 clk = ~clk;

  lifo_regstack #(.WIDTH(W), .PTR_W(PW)) i_lifo_regstack (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_data(push_data),
    .pop_req(pop_req), .pop_vld(pop_vld), .pop_data(pop_data),
    .full(full), .empty(empty), .err(err)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic pu, input logic po);
    return (pu && (m_full || po)) || (po && m_empty);
  endfunction

  task automatic step(input logic pu, input logic po, input logic [W-1:0] d, input string req);
    logic e_err, e_vld;
    @(negedge clk);
    push_vld  = pu;
    pop_req   = po;
    push_data = d;
    e_err = exp_err(pu, po);
    e_vld = 1'b0;
    if (po && !m_empty) begin
      e_vld   = 1'b1;
      m_data  = m_mem[m_sp];
      m_sp    = m_sp - 1'b1;
      m_empty = (m_sp == '0);
      m_full  = 1'b0;
    end else if (pu && !po && !m_full) begin
      m_sp        = m_sp + 1'b1;
      m_mem[m_sp] = d;
      m_full      = (m_sp == '0);
      m_empty     = 1'b0;
    end
    @(posedge clk);
    #1;
    push_vld = 1'b0;
    pop_req  = 1'b0;
    check(req, "pop_vld", W'(pop_vld), W'(e_vld));
    check(req, "pop_data", pop_data, m_data);
    check(req, "err", W'(err), W'(e_err));
    check(req, "full", W'(full), W'(m_full));
    check(req, "empty", W'(empty), W'(m_empty));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "empty", W'(empty), W'(1));
    check("R1", "full", W'(full), W'(0));
    check("R1", "pop_vld", W'(pop_vld), W'(0));
    check("R1", "err", W'(err), W'(0));

    // R4 pop on empty
    step(1'b0, 1'b1, '0, "R4");
    step(1'b0, 1'b0, '0, "R7");
    // R2 LIFO order, R5 empty cleared
    step(1'b1, 1'b0, 16'h1111, "R5");
    step(1'b1, 1'b0, 16'h2222, "R2");
    step(1'b1, 1'b0, 16'h3333, "R2");
    // R6 simultaneous on partly filled stack
    step(1'b1, 1'b1, 16'hDEAD, "R6");
    step(1'b0, 1'b1, '0, "R2");
    step(1'b0, 1'b1, '0, "R2");
    step(1'b0, 1'b1, '0, "R4");
    // R6 simultaneous on empty stack
    step(1'b1, 1'b1, 16'hBEEF, "R6");
    // R9 fill to capacity
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, W'(16'hA000 + i), "R9");
    check("R9", "full after 64", W'(full), W'(1));
    // R3 push while full
    step(1'b1, 1'b0, 16'h5555, "R3");
    step(1'b1, 1'b0, 16'h6666, "R3");
    // R6 simultaneous on full stack
    step(1'b1, 1'b1, 16'h7777, "R6");
    step(1'b1, 1'b0, 16'hA03F, "R5");
    // R3 drain, original contents back in reverse
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, '0, "R3");
    check("R9", "empty after drain", W'(empty), W'(1));
    step(1'b0, 1'b1, '0, "R4");

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      for (int k = 0; k < 400; k++) begin
        int unsigned r = $urandom % 100;
        logic pu, po;
        if (ph % 2 == 0) begin
          pu = (r < 75);
          po = (r >= 65 && r < 85);
        end else begin
          pu = (r < 25);
          po = (r >= 15 && r < 85);
        end
        step(pu, po, W'($urandom), "R8");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule